// File: doc/BRIEF.md
# Microslice Timestamp Framer

The framer keeps a 64-bit timestamp that counts system clock ticks while a run is enabled. It cuts the outgoing data stream into microslices whose length is programmed in ticks. Each payload word (a counter or trigger record with a small type tag) leaves the block with a short timestamp: the low 27 bits of the counter, taken in the cycle the word is accepted. When a microslice ends, the block emits a single closing word that carries the full 64-bit counter value. A consumer can rebuild the full time of every payload word from the nearest closing word, because a microslice never spans more than one wrap of the short field.

Raising the run enable restarts the counter and the microslice phase from zero. The first microslice of the run is emitted like every other one. An optional word-count rollover can mark a packet end on payload words between closing words. Output is a valid/ready stream. A small two-write buffer absorbs backpressure, and its input handshake holds back requests instead of dropping them.

Top module: `ts_framer`

## Requirements
- R1: On the cycle after the run enable rises, the timestamp counter is 0. While the run stays enabled, the counter then advances by one on every cycle with `tick_i` high.
- R2: A payload word accepted while the counter holds value T leaves the block with `out_is_ts_o`=0. It carries its own tag and data, and `out_ts_o` equals T mod 2^27 with bits 63..27 zero.
- R3: A closing word has `out_is_ts_o`=1, `out_last_o`=1 and tag and data zero. It is produced on the tick that brings the count of ticks since the previous closing word (or since run start) to the slice length. `out_ts_o` holds the full counter value after that tick.
- R4: The first microslice of a run is kept. The first closing word after run start carries exactly the slice length.
- R5: A slice length of 0 acts as 1, which gives one closing word per tick.
- R6: If a payload word is accepted in the same cycle as a microslice ends, the payload word is emitted before the closing word.
- R7: With rollover N>0, the Nth payload word counted from the last closing word or rollover point has `out_last_o`=1. With N=0, payload words always have `out_last_o`=0.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output word holds still. No accepted word is lost or reordered.
- R9: While the run enable is low, `req_ready_o` is 0 and no closing words are produced.
- R10: Raising the run enable again in the middle of a microslice restarts the slice phase, so the next closing word carries the slice length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Run enable; a rising edge starts a run |
| tick_i | input | 1 | Timestamp tick |
| slice_len_i | input | LEN_W | Microslice length in ticks (0 acts as 1) |
| roll_words_i | input | ROLL_W | Payload words per packet, 0 = off |
| req_valid_i | input | 1 | Payload word request |
| req_tag_i | input | 2 | Payload type tag |
| req_data_i | input | 32 | Payload data |
| req_ready_o | output | 1 | Request accepted this cycle |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_is_ts_o | output | 1 | 1 = closing full-timestamp word |
| out_last_o | output | 1 | Packet end marker |
| out_tag_o | output | 2 | Payload tag |
| out_data_o | output | 32 | Payload data |
| out_ts_o | output | 64 | Full or short timestamp |

## Verification
The bench builds the block with an 8-entry buffer and an 8-bit rollover field. The deeper buffer lets the output stall for about 25 cycles while microslices keep closing, so the spill register fills and drains, and no word has to be given up. Slice lengths of 0 to 10 ticks produce dozens of closing words in a short run, including ones that coincide with payload acceptance. A rollover of 3 produces several packet ends inside each slice.

// File: rtl/ts_framer_pkg.sv
package ts_framer_pkg;
  localparam int TS_W    = 64;
  localparam int SHORT_W = 27;
  localparam int TAG_W   = 2;
  localparam int DATA_W  = 32;

  typedef struct packed {
    logic              is_ts;
    logic              last;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
    logic [TS_W-1:0]   ts;
  } word_t;
endpackage

// File: rtl/ts_slice_timer.sv
module ts_slice_timer #(
  parameter int TS_W  = 64,
  parameter int LEN_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [TS_W-1:0]  ts_o,
  output logic             bnd_o,
  output logic [TS_W-1:0]  bnd_ts_o
);
  logic [TS_W-1:0]  ts_q;
  logic [LEN_W-1:0] sc_q;
  logic [LEN_W-1:0] len_eff;
  logic [LEN_W:0]   sc_inc;

  assign len_eff  = (len_i == '0) ? LEN_W'(1) : len_i;
  assign sc_inc   = {1'b0, sc_q} + (LEN_W+1)'(1);
  // >= so a length lowered mid-slice closes at once
  assign bnd_o    = run_i & tick_i & (sc_inc >= {1'b0, len_eff});
  assign bnd_ts_o = ts_q + TS_W'(1);
  assign ts_o     = ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q <= '0;
      sc_q <= '0;
    end else if (start_i) begin
      ts_q <= '0;
      sc_q <= '0;
    end else if (run_i && tick_i) begin
      ts_q <= bnd_ts_o;
      sc_q <= bnd_o ? '0 : sc_inc[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/ts_word_builder.sv
module ts_word_builder
  import ts_framer_pkg::*;
#(
  parameter int ROLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              acc_i,
  input  logic              bnd_i,
  input  logic [ROLL_W-1:0] roll_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [TS_W-1:0]   bnd_ts_i,
  output word_t             pay_o,
  output word_t             tsw_o
);
  localparam int PAD_W = TS_W - SHORT_W;

  logic [ROLL_W-1:0] wc_q;
  logic [ROLL_W:0]   wc_inc;
  logic              roll_hit;

  assign wc_inc   = {1'b0, wc_q} + (ROLL_W+1)'(1);
  assign roll_hit = (roll_i != '0) && (wc_inc >= {1'b0, roll_i});

  always_comb begin
    pay_o       = '0;
    pay_o.last  = roll_hit;
    pay_o.tag   = tag_i;
    pay_o.data  = data_i;
    pay_o.ts    = {{PAD_W{1'b0}}, ts_i[SHORT_W-1:0]};
    tsw_o       = '0;
    tsw_o.is_ts = 1'b1;
    tsw_o.last  = 1'b1;
    tsw_o.ts    = bnd_ts_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               wc_q <= '0;
    else if (start_i || bnd_i) wc_q <= '0;
    else if (acc_i)            wc_q <= roll_hit ? '0 : wc_inc[ROLL_W-1:0];
  end
endmodule

// File: rtl/ts_skid_fifo.sv
module ts_skid_fifo
  import ts_framer_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we0_i,
  input  word_t                    d0_i,
  input  logic                     we1_i,
  input  word_t                    d1_i,
  output logic [$clog2(DEPTH):0]   free_o,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output word_t                    out_o
);
  localparam int AW = $clog2(DEPTH);

  word_t         mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_nx;
  logic [AW:0]   cnt_q;
  logic          pop;
  logic [AW:0]   n_push;

  assign wr_nx       = wr_q + AW'(1);
  assign out_valid_o = (cnt_q != '0);
  assign out_o       = mem[rd_q];
  assign pop         = out_valid_o & out_ready_i;
  assign free_o      = (AW+1)'(DEPTH) - cnt_q;
  assign n_push      = (AW+1)'(we0_i) + (AW+1)'(we1_i);

  always_ff @(posedge clk_i) begin
    if (we0_i) mem[wr_q]  <= d0_i;
    if (we1_i) mem[wr_nx] <= d1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + AW'(n_push);
      if (pop) rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + n_push - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/ts_framer.sv
module ts_framer
  import ts_framer_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LEN_W  = SHORT_W,
  parameter int ROLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_en_i,
  input  logic              tick_i,
  input  logic [LEN_W-1:0]  slice_len_i,
  input  logic [ROLL_W-1:0] roll_words_i,
  input  logic              req_valid_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_is_ts_o,
  output logic              out_last_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [TS_W-1:0]   out_ts_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);
  localparam logic [AW:0] TWO = (AW+1)'(2);

  logic            run_q, start, run_act, acc;
  logic [TS_W-1:0] ts_now, bnd_ts;
  logic            bnd;
  word_t           pay_w, ts_w, hold_q, c0, c1, head;
  logic            hold_v_q, c0_v, c1_v, we0, we1;
  logic [AW:0]     free;

  assign start   = run_en_i & ~run_q;
  assign run_act = run_en_i & run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_en_i;
  end

  ts_slice_timer #(.TS_W(TS_W), .LEN_W(LEN_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (run_act),
    .tick_i   (tick_i),
    .len_i    (slice_len_i),
    .ts_o     (ts_now),
    .bnd_o    (bnd),
    .bnd_ts_o (bnd_ts)
  );

  // one slot stays free so a closing word can always follow a payload word
  assign req_ready_o = run_act & ~hold_v_q & (free >= TWO);
  assign acc         = req_valid_i & req_ready_o;

  ts_word_builder #(.ROLL_W(ROLL_W)) u_build (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .acc_i    (acc),
    .bnd_i    (bnd),
    .roll_i   (roll_words_i),
    .tag_i    (req_tag_i),
    .data_i   (req_data_i),
    .ts_i     (ts_now),
    .bnd_ts_i (bnd_ts),
    .pay_o    (pay_w),
    .tsw_o    (ts_w)
  );

  // write order: spilled word or payload first, closing word second
  always_comb begin
    c0   = ts_w;
    c0_v = bnd;
    c1   = ts_w;
    c1_v = 1'b0;
    if (hold_v_q) begin
      c0   = hold_q;
      c0_v = 1'b1;
      c1_v = bnd;
    end else if (acc) begin
      c0   = pay_w;
      c0_v = 1'b1;
      c1_v = bnd;
    end
  end

  assign we0 = c0_v & (free >= ONE);
  assign we1 = c1_v & we0 & (free >= TWO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else if (c1_v && !we1) begin
      hold_v_q <= 1'b1;
      hold_q   <= c1;
    end else if (c0_v && !we0 && !hold_v_q) begin
      hold_v_q <= 1'b1;
      hold_q   <= c0;
    end else if (hold_v_q && we0) begin
      hold_v_q <= 1'b0;
    end
  end

  ts_skid_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we0_i       (we0),
    .d0_i        (c0),
    .we1_i       (we1),
    .d1_i        (c1),
    .free_o      (free),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_o       (head)
  );

  assign out_is_ts_o = head.is_ts;
  assign out_last_o  = head.last;
  assign out_tag_o   = head.tag;
  assign out_data_o  = head.data;
  assign out_ts_o    = head.ts;
endmodule

// File: rtl/ts_framer_chk.sv
module ts_framer_chk
  import ts_framer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_en_i,
  input logic              req_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_is_ts_o,
  input logic              out_last_o,
  input logic [TAG_W-1:0]  out_tag_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [TS_W-1:0]   out_ts_o,
  input logic [TS_W-1:0]   ts_cnt_i
);
  p_run_start_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_i) |=> (ts_cnt_i == '0));

  p_short_ts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_is_ts_o) |-> (out_ts_o[TS_W-1:SHORT_W] == '0));

  p_close_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_is_ts_o) |-> (out_last_o && out_tag_o == '0 && out_data_o == '0));

  p_stall_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_ts_o) && $stable(out_data_o) &&
       $stable(out_is_ts_o) && $stable(out_last_o) && $stable(out_tag_o)));

  p_idle_no_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |-> !req_ready_o);
endmodule

bind ts_framer ts_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_en_i    (run_en_i),
  .req_ready_o (req_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_is_ts_o (out_is_ts_o),
  .out_last_o  (out_last_o),
  .out_tag_o   (out_tag_o),
  .out_data_o  (out_data_o),
  .out_ts_o    (out_ts_o),
  .ts_cnt_i    (ts_now)
);

// File: tb/ts_framer_tb.sv
module ts_framer_tb;
  import ts_framer_pkg::*;

  localparam int DEPTH  = 8;
  localparam int LEN_W  = 27;
  localparam int ROLL_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              run_en_i = 1'b0;
  logic              tick_i = 1'b0;
  logic [LEN_W-1:0]  slice_len_i = '0;
  logic [ROLL_W-1:0] roll_words_i = '0;
  logic              req_valid_i = 1'b0;
  logic [TAG_W-1:0]  req_tag_i = '0;
  logic [DATA_W-1:0] req_data_i = '0;
  logic              req_ready_o;
  logic              out_valid_o;
  logic              out_ready_i = 1'b1;
  logic              out_is_ts_o, out_last_o;
  logic [TAG_W-1:0]  out_tag_o;
  logic [DATA_W-1:0] out_data_o;
  logic [TS_W-1:0]   out_ts_o;

  always #2.5 clk_i = ~clk_i;

  ts_framer #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ROLL_W(ROLL_W)) u_dut (.*);

  int total = 0;
  int bad   = 0;

  word_t     expq[$];
  longint    m_ts;
  int        m_sc, m_wc;
  bit        m_run_q;
  bit        first_pend;
  string     first_lbl;
  string     phase;
  bit        prev_stall;
  word_t     snap;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic word_t out_word();
    word_t w;
    w.is_ts = out_is_ts_o; w.last = out_last_o; w.tag = out_tag_o;
    w.data  = out_data_o;  w.ts   = out_ts_o;
    return w;
  endfunction

  function automatic int eff_len(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  // one cycle: inputs already set, sampled 1 ns after negedge
  task automatic cyc();
    word_t got, exp;
    bit    acc, start, running;
    int    wn;
    bit    hit;
    got = out_word();
    if (prev_stall) begin
      check(out_valid_o && got == snap, "R8", "stalled word changed",
            longint'(got.ts), longint'(snap.ts));
    end
    prev_stall = out_valid_o && !out_ready_i;
    snap = got;
    if (out_valid_o && out_ready_i) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8", "unexpected word", longint'(got.ts), 0);
      end else begin
        exp = expq.pop_front();
        check(got == exp, exp.is_ts ? {"R3/", phase} : {"R2/", phase},
              "word mismatch (ts)", longint'(got.ts), longint'(exp.ts));
        if (got.data != exp.data || got.last != exp.last || got.is_ts != exp.is_ts)
          $display("  detail: data %0h/%0h last %0b/%0b is_ts %0b/%0b",
                   got.data, exp.data, got.last, exp.last, got.is_ts, exp.is_ts);
        if (got.is_ts && first_pend) begin
          first_pend = 1'b0;
          check(got.ts == longint'(eff_len(int'(slice_len_i))), first_lbl,
                "first closing word", longint'(got.ts), longint'(eff_len(int'(slice_len_i))));
        end
      end
    end
    // reference model
    running = m_run_q && run_en_i;
    start   = run_en_i && !m_run_q;
    acc     = req_valid_i && req_ready_o;
    if (start) begin
      m_ts = 0; m_sc = 0; m_wc = 0;
    end
    if (acc) begin
      wn  = m_wc + 1;
      hit = (roll_words_i != 0) && (wn >= int'(roll_words_i));
      exp = '0;
      exp.last = hit; exp.tag = req_tag_i; exp.data = req_data_i;
      exp.ts = TS_W'(m_ts & longint'(32'h07ff_ffff));
      expq.push_back(exp);
      m_wc = hit ? 0 : wn;
    end
    if (running && tick_i) begin
      m_ts++; m_sc++;
      if (m_sc >= eff_len(int'(slice_len_i))) begin
        exp = '0; exp.is_ts = 1'b1; exp.last = 1'b1; exp.ts = TS_W'(m_ts);
        expq.push_back(exp);
        m_sc = 0; m_wc = 0;
      end
    end
    m_run_q = run_en_i;
    @(negedge clk_i);
    #1;
  endtask

  task automatic rand_req();
    req_valid_i = ($urandom_range(0, 1) == 1);
    req_tag_i   = TAG_W'($urandom_range(0, 3));
    req_data_i  = $urandom();
  endtask

  task automatic drain();
    run_en_i = 1'b0; req_valid_i = 1'b0; out_ready_i = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (expq.size() == 0 && !out_valid_o) break;
      cyc();
    end
    check(expq.size() == 0, "R8", "words left undelivered", expq.size(), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    phase = "R1"; first_lbl = "R4";
    m_ts = 0; m_sc = 0; m_wc = 0; m_run_q = 0; first_pend = 0; prev_stall = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(!out_valid_o, "R9", "reset out_valid", out_valid_o, 0);
    check(!req_ready_o, "R9", "reset req_ready", req_ready_o, 0);

    // idle: requests and ticks have no effect
    phase = "R9";
    req_valid_i = 1'b1; tick_i = 1'b1; slice_len_i = 2;
    for (int i = 0; i < 20; i++) begin
      check(!req_ready_o, "R9", "ready while idle", req_ready_o, 0);
      check(!out_valid_o, "R9", "output while idle", out_valid_o, 0);
      cyc();
    end

    // start, every-cycle ticks, len 5
    phase = "R1"; slice_len_i = 5; roll_words_i = 0;
    run_en_i = 1'b1; first_pend = 1; first_lbl = "R4";
    for (int i = 0; i < 60; i++) begin rand_req(); cyc(); end

    // zero length acts as one
    phase = "R5"; slice_len_i = 0;
    for (int i = 0; i < 40; i++) begin rand_req(); tick_i = ($urandom_range(0, 2) != 0); cyc(); end

    // coincident payload and closing words
    phase = "R6"; slice_len_i = 4; tick_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      req_valid_i = 1'b1; req_tag_i = TAG_W'(i); req_data_i = 32'(i + 100); cyc();
    end

    // rollover, random ticks and backpressure
    phase = "R7"; slice_len_i = 7; roll_words_i = 3;
    for (int i = 0; i < 200; i++) begin
      rand_req(); tick_i = ($urandom_range(0, 1) == 1);
      out_ready_i = ($urandom_range(0, 1) == 1); cyc();
    end
    out_ready_i = 1'b1;

    // restart in mid slice
    phase = "R10"; slice_len_i = 6; roll_words_i = 0; tick_i = 1'b1; req_valid_i = 1'b0;
    for (int i = 0; i < 9; i++) cyc();
    run_en_i = 1'b0; cyc();
    check(!req_ready_o, "R9", "ready after stop", req_ready_o, 0);
    run_en_i = 1'b1; first_pend = 1; first_lbl = "R10";
    for (int i = 0; i < 30; i++) begin rand_req(); cyc(); end
    check(!first_pend, "R10", "closing word after restart seen", first_pend, 0);

    // long stall with slices closing
    phase = "R8"; slice_len_i = 10; out_ready_i = 1'b0;
    for (int i = 0; i < 25; i++) begin rand_req(); cyc(); end
    out_ready_i = 1'b1;
    for (int i = 0; i < 30; i++) begin rand_req(); cyc(); end

    drain();
    phase = "R9"; tick_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      check(!out_valid_o, "R9", "closing word while stopped", out_valid_o, 0);
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule